// File: doc/BRIEF.md
# Dual-Format Audio Serial Transmitter

This block is the slave-side serial output of a stereo audio converter. It takes a left and a right sample, each a 20-bit two's complement value, and shifts them out on one serial data line. An external controller drives the bit clock and the frame clock. The block samples both clocks with its own system clock and synchronises them. Its output changes after each falling bit-clock edge, so the controller can latch data on the rising edge.

A format input selects one of two framings. In justified framing the frame clock is high for the left channel and the first data bit follows the frame-clock transition directly. In I2S-style framing the polarity is inverted and every word starts one bit clock later. The last bit of a word that fills its half-frame then spills into the first slot of the next half.

The word length depends on the bit-clock rate. The block counts falling bit-clock edges between successive left-channel starts. A frame of 40 or more bits gives full 20-bit words, padded with zeros. Fewer bits give the upper 16 bits only. At each left-channel start the block also captures the right sample into a holding register, so that changes to the inputs during a frame cannot corrupt the words being sent.

Top module: `aud_ser_tx`

## Requirements
- R1: After reset `sdata_o` stays 0 until the first change of the synchronised frame clock that is seen at a falling bit-clock edge.
- R2: `sdata_o` changes only on the system-clock cycle that follows a detected falling bit-clock edge. It holds its value while the bit clock is high.
- R3: Each word is sent most significant bit first, as bit 19, 18, … of the two's complement sample, one bit per bit-clock period.
- R4: With `fmt_i2s_i` = 0, frame clock high marks the left channel and frame clock low the right. The MSB is driven in the slot that begins at the falling edge where the frame clock changes.
- R5: With `fmt_i2s_i` = 1, frame clock low marks the left channel and high the right. The MSB appears one slot after the frame-clock change. That first slot carries the next unsent bit of the previous word, or 0 if that word is already finished.
- R6: When the previous frame held fewer than 40 bit clocks (32 in normal use), each word is 16 bits: sample bits 19 down to 4, followed by zeros.
- R7: When the previous frame held 40 or more bit clocks, each word is the full 20 bits. The line is 0 in every slot after the LSB until the next word starts.
- R8: The frame length is counted from one left-channel start to the next. The word length is updated only at a left-channel start. The first frame after reset always uses 16-bit words.
- R9: The left sample is taken from `left_i`, and `right_i` is captured, at the falling edge that starts the left channel. Later changes to either input do not affect the words of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bit clock from the external controller |
| frame_i | input | 1 | Frame (channel-select) clock from the external controller |
| fmt_i2s_i | input | 1 | Framing select: 0 justified, 1 I2S-style |
| left_i | input | 20 | Left sample, two's complement |
| right_i | input | 20 | Right sample, two's complement |
| sdata_o | output | 1 | Serial data output |

## Verification
The checker watches four things on every cycle. The line stays quiet until the block is armed. The output moves only right after a detected falling bit-clock edge. The word-length flag and the right holding register change only at a left-channel start.

Some behaviour shows only in the bench's frame sequences, which compare every slot against a model of the serial stream. This covers the bit order, the polarity and one-slot delay of each format, truncation to 16 bits and zero padding at the longer rates, and the I2S spill of the LSB into the next half. It also covers the first-frame default of 16 bits and the immunity of a frame to sample changes made during it.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

   typedef enum logic {
      FMT_JUSTIFIED = 1'b0,
      FMT_I2S       = 1'b1
   } aud_fmt_e;

   // Frame-clock level that marks the left channel for a given framing
   function automatic logic level_is_left(input logic lvl, input aud_fmt_e fmt);
      return (fmt == FMT_JUSTIFIED) ? lvl : ~lvl;
   endfunction

endpackage

// File: rtl/aud_tx_edge.sv
module aud_tx_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_in,
   input  logic frame_in,
   output logic fall_o,
   output logic frame_lvl_o
);

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("aud_tx_edge: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] bsync;
   logic [STAGES-1:0] fsync;
   logic              bprev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bsync <= '0;
         fsync <= '0;
         bprev <= 1'b0;
      end else begin
         bsync[0] <= bclk_in;
         fsync[0] <= frame_in;
         for (int i = 1; i < STAGES; i++) begin
            bsync[i] <= bsync[i-1];
            fsync[i] <= fsync[i-1];
         end
         bprev <= bsync[LAST];
      end
   end

   assign fall_o      = bprev & ~bsync[LAST];
   assign frame_lvl_o = fsync[LAST];

endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
   import aud_tx_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int WIDE_BPF = 40
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fall_i,
   input  logic     lvl_i,
   input  aud_fmt_e fmt_i,
   output logic     chan_start_o,
   output logic     left_start_o,
   output logic     armed_o,
   output logic     wide_sel_o,
   output logic     wide_q_o
);

   localparam logic [CNT_W-1:0] WIDE_LIM = CNT_W'(WIDE_BPF);

   generate
      if (WIDE_BPF >= (1 << CNT_W)) begin : g_bad_cnt
         $error("aud_tx_framer: CNT_W too small for WIDE_BPF");
      end
   endgenerate

   logic             seen;
   logic             lvl_prev;
   logic             armed;
   logic             len_valid;
   logic             wide_q;
   logic [CNT_W-1:0] bit_cnt;
   logic             edge_ev;
   logic             left_ev;

   assign edge_ev = fall_i & seen & (lvl_i != lvl_prev);
   assign left_ev = edge_ev & level_is_left(lvl_i, fmt_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen      <= 1'b0;
         lvl_prev  <= 1'b0;
         armed     <= 1'b0;
         len_valid <= 1'b0;
         wide_q    <= 1'b0;
         bit_cnt   <= '0;
      end else begin
         if (fall_i) begin
            seen     <= 1'b1;
            lvl_prev <= lvl_i;
         end
         if (edge_ev) armed <= 1'b1;
         if (left_ev) begin
            bit_cnt   <= CNT_W'(1);
            len_valid <= 1'b1;
            if (len_valid) wide_q <= (bit_cnt >= WIDE_LIM);
         end else if (fall_i && bit_cnt != '1) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
         end
      end
   end

   assign chan_start_o = edge_ev;
   assign left_start_o = left_ev;
   assign armed_o      = armed;
   assign wide_q_o     = wide_q;
   assign wide_sel_o   = (left_ev && len_valid) ? (bit_cnt >= WIDE_LIM) : wide_q;

endmodule

// File: rtl/aud_tx_shifter.sv
module aud_tx_shifter
   import aud_tx_pkg::*;
#(
   parameter int SAMPLE_W = 20,
   parameter int SHORT_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fall_i,
   input  logic                chan_start_i,
   input  logic                left_start_i,
   input  aud_fmt_e            fmt_i,
   input  logic                wide_i,
   input  logic [SAMPLE_W-1:0] left_i,
   input  logic [SAMPLE_W-1:0] right_i,
   output logic [SAMPLE_W-1:0] hold_o,
   output logic                sdo_o
);

   localparam int PAD_W = SAMPLE_W - SHORT_W;

   logic [SAMPLE_W-1:0] hold_r;
   logic [SAMPLE_W-1:0] raw_word;
   logic [SAMPLE_W-1:0] word;
   logic [SAMPLE_W-1:0] sr;
   logic                sdo;

   assign raw_word = left_start_i ? left_i : hold_r;

   generate
      if (PAD_W == 0) begin : g_no_trunc
         logic unused_wide;
         assign unused_wide = wide_i;
         assign word = raw_word;
      end else begin : g_trunc
         localparam logic [SAMPLE_W-1:0] SHORT_MASK = {{SHORT_W{1'b1}}, {PAD_W{1'b0}}};
         assign word = wide_i ? raw_word : (raw_word & SHORT_MASK);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_r <= '0;
         sr     <= '0;
         sdo    <= 1'b0;
      end else if (fall_i) begin
         if (left_start_i) hold_r <= right_i;
         if (chan_start_i) begin
            if (fmt_i == FMT_I2S) begin
               sdo <= sr[SAMPLE_W-1];
               sr  <= word;
            end else begin
               sdo <= word[SAMPLE_W-1];
               sr  <= word << 1;
            end
         end else begin
            sdo <= sr[SAMPLE_W-1];
            sr  <= sr << 1;
         end
      end
   end

   assign hold_o = hold_r;
   assign sdo_o  = sdo;

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
   import aud_tx_pkg::*;
#(
   parameter int SAMPLE_W    = 20,
   parameter int SHORT_W     = 16,
   parameter int WIDE_BPF    = 40,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_i,
   input  logic                frame_i,
   input  logic                fmt_i2s_i,
   input  logic [SAMPLE_W-1:0] left_i,
   input  logic [SAMPLE_W-1:0] right_i,
   output logic                sdata_o
);

   generate
      if (SHORT_W < 1 || SHORT_W > SAMPLE_W) begin : g_bad_width
         $error("aud_ser_tx: SHORT_W must lie in 1..SAMPLE_W");
      end
   endgenerate

   aud_fmt_e            fmt;
   logic                fall;
   logic                lvl;
   logic                chan_start;
   logic                left_start;
   logic                armed;
   logic                wide_sel;
   logic                wide_q;
   logic [SAMPLE_W-1:0] hold;

   assign fmt = aud_fmt_e'(fmt_i2s_i);

   aud_tx_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .bclk_in    (bclk_i),
      .frame_in   (frame_i),
      .fall_o     (fall),
      .frame_lvl_o(lvl)
   );

   aud_tx_framer #(.CNT_W(CNT_W), .WIDE_BPF(WIDE_BPF)) u_frm (
      .clk         (clk),
      .rst_n       (rst_n),
      .fall_i      (fall),
      .lvl_i       (lvl),
      .fmt_i       (fmt),
      .chan_start_o(chan_start),
      .left_start_o(left_start),
      .armed_o     (armed),
      .wide_sel_o  (wide_sel),
      .wide_q_o    (wide_q)
   );

   aud_tx_shifter #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_shf (
      .clk         (clk),
      .rst_n       (rst_n),
      .fall_i      (fall),
      .chan_start_i(chan_start),
      .left_start_i(left_start),
      .fmt_i       (fmt),
      .wide_i      (wide_sel),
      .left_i      (left_i),
      .right_i     (right_i),
      .hold_o      (hold),
      .sdo_o       (sdata_o)
   );

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk #(
   parameter int SAMPLE_W = 20
) (
   input logic                clk,
   input logic                rst_n,
   input logic                fall,
   input logic                left_start,
   input logic                armed,
   input logic                wide_q,
   input logic [SAMPLE_W-1:0] hold,
   input logic                sdata_o
);

   AST_QUIET_UNTIL_ARMED: assert property (@(posedge clk) disable iff (!rst_n) !armed |-> !sdata_o); // R1
   AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $past(armed) |-> armed); // R1
   AST_MOVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$past(fall) |-> $stable(sdata_o)); // R2
   AST_LEN_AT_LEFT: assert property (@(posedge clk) disable iff (!rst_n) !$past(left_start) |-> $stable(wide_q)); // R8
   AST_HOLD_AT_LEFT: assert property (@(posedge clk) disable iff (!rst_n) !$past(left_start) |-> $stable(hold)); // R9

endmodule

bind aud_ser_tx aud_ser_tx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fall      (fall),
   .left_start(left_start),
   .armed     (armed),
   .wide_q    (wide_q),
   .hold      (hold),
   .sdata_o   (sdata_o)
);

// File: tb/sim_aud_ser_tx.sv
`timescale 1ns/1ps
module sim_aud_ser_tx;

   localparam int H = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b1;
   logic        lrck = 1'b0;
   logic        fmt = 1'b0;
   logic [19:0] left_s = '0;
   logic [19:0] right_s = '0;
   logic        sdata;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   aud_ser_tx u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_i   (bclk),
      .frame_i  (lrck),
      .fmt_i2s_i(fmt),
      .left_i   (left_s),
      .right_i  (right_s),
      .sdata_o  (sdata)
   );

   task automatic check(input logic got, input logic exp, input string tag, input string what);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b", tag, what, got, exp);
      end
   endtask

   function automatic logic [19:0] trunc_word(input logic [19:0] x, input int w);
      return (w == 20) ? x : (x & 20'hFFFF0);
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_segment(input bit f, input int nframes);
      logic [19:0] lv, rv, prev_word, word;
      int          prev_n, prev_bpf;
      @(negedge clk);
      rst_n = 1'b0; fmt = f; bclk = 1'b1;
      lrck = f ? 1'b1 : 1'b0;   // right-channel level for this framing
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      // R1: idle bit clocks without a frame edge keep the line low
      for (int i = 0; i < 4; i++) begin
         bclk = 1'b0; wait_clk(H);
         check(sdata, 1'b0, "R1", "idle before first frame edge");
         bclk = 1'b1; wait_clk(H);
      end
      lv = 20'($urandom); rv = 20'($urandom);
      left_s = lv; right_s = rv;
      prev_word = '0; prev_n = 0; prev_bpf = 0;
      for (int k = 0; k < nframes; k++) begin
         int bpf, w, n;
         bit wide;
         case (k)
            0: bpf = 40;
            1: bpf = 32;
            2: bpf = 48;
            3: bpf = 32;
            default: case ($urandom_range(0, 3))
               0: bpf = 32;
               1: bpf = 40;
               2: bpf = 48;
               default: bpf = 64;
            endcase
         endcase
         wide = (k > 0) && (prev_bpf >= 40);
         w = wide ? 20 : 16;
         n = bpf / 2;
         for (int ch = 0; ch < 2; ch++) begin
            word = trunc_word(ch == 0 ? lv : rv, w);
            for (int s = 0; s < n; s++) begin
               logic exp, got;
               int pos;
               string tag;
               bclk = 1'b0;
               if (s == 0) lrck = (ch == 0) ? ~f : f;
               wait_clk(H);
               pos = s - int'(f);
               if (pos >= 0) begin
                  exp = (pos < w) ? word[19-pos] : 1'b0;
               end else begin
                  exp = (prev_n - 1 < 20 && prev_n > 0) ? prev_word[20-prev_n] : 1'b0;
               end
               if (pos >= w) tag = "R7";
               else if (k == 0) tag = "R8";
               else if (ch == 1) tag = "R9";
               else if (!wide) tag = "R6";
               else if (s <= 1) tag = f ? "R5" : "R4";
               else tag = "R3";
               check(sdata, exp, tag, $sformatf("frame %0d ch %0d slot %0d bpf %0d fmt %0b", k, ch, s, bpf, f));
               got = sdata;
               bclk = 1'b1;
               if (ch == 0 && s == 2) begin
                  left_s = 20'($urandom); right_s = 20'($urandom);   // R9 disturbance
               end
               if (ch == 1 && s == n - 1) begin
                  lv = 20'($urandom); rv = 20'($urandom);
                  if (k % 3 == 2) begin lv = 20'h80000; rv = 20'h7FFFF; end
                  left_s = lv; right_s = rv;
               end
               wait_clk(H / 2);
               check(sdata, got, "R2", "line moved while bit clock high");
               wait_clk(H - H / 2);
            end
            prev_word = word; prev_n = n;
         end
         prev_bpf = bpf;
      end
   endtask

   initial begin
      void'($urandom(32'h1A5D));
      run_segment(1'b0, 10);
      run_segment(1'b1, 10);
      run_segment(1'b0, 6);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule